// File: doc/BRIEF.md
# Ring-Oscillator Entropy Word Collector

This block gathers raw randomness from a bank of free-running digital oscillators and packs it into 32-bit words for a downstream consumer. Each oscillator is a small adder whose carry-out is inverted and fed back as its own carry-in, so the carry toggles continuously. The two adder operands come in on ports, which keeps the oscillator logic from being folded into constants. Every oscillator output first passes through a capture flop.

A programmable prescaler produces a single-cycle sample tick that runs far slower than the oscillators toggle, so their phases drift apart between samples. On each tick, the captured outputs are XOR-reduced to one raw bit, and that bit is shifted into a word register. After 32 samples the word is offered on a valid/ack handshake. For testing, a select input replaces the oscillator outputs with a vector that the bench drives. Because the ring variant is an asynchronous loop, a parameter chooses between that loop and a clocked stand-in that behaves the same way.

Top module: `entropy_word_collector`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `word_valid` is 0 and `word_data` is 0.
- R2: With `enable` high, the first sample is taken on the (period_cfg+2)-th rising edge that sees `enable` high. Each later sample is taken period_cfg+1 edges after the one before it. A period_cfg of 0 samples on every edge after the first.
- R3: When `force_sel` is 1, each raw bit is the XOR of all 32 bits of `force_bits` at the sampling edge.
- R4: The first raw bit of a word lands in bit 31 and the last in bit 0. `word_valid` rises on the edge that takes the 32nd sample of the word.
- R5: While `word_valid` is high and `word_ack` is low, `word_valid` stays high and `word_data` does not change.
- R6: When `word_ack` is high while `word_valid` is high and no word completes on that edge, `word_valid` is 0 after the edge.
- R7: A word that completes while an earlier word is still held without ack is discarded. The held word stays on `word_data`.
- R8: When `enable` is low, `word_valid` drops after the next edge and the bit count returns to zero. After `enable` is raised again, a complete fresh set of 32 samples is needed for the next word.
- R9: When `force_sel` is 0, the live oscillator bank feeds the sampler, and a word is offered after 32 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows sampling; when low, clears the handshake and the bit count |
| period_cfg | input | 16 | Prescaler reload; the sample period is period_cfg+1 clocks |
| opnd_a | input | 4 | First adder operand shared by all oscillators |
| opnd_b | input | 4 | Second adder operand shared by all oscillators |
| force_sel | input | 1 | Selects `force_bits` instead of the oscillator outputs |
| force_bits | input | 32 | Test vector that replaces the oscillator outputs |
| word_ack | input | 1 | Consumer takes the offered word |
| word_data | output | 32 | Offered entropy word |
| word_valid | output | 1 | A word is held on `word_data` |

## Verification
The assertions assume that `period_cfg` is changed only while `enable` is low. They also assume that `word_ack` is a plain level that the consumer may hold for any length of time. The bench writes the period only during a disabled interval, and it pulses ack for one cycle at a time. When the bench forces the source, it changes `force_bits` only on a falling edge inside the sample window and holds it across the sampling edge. The source is therefore stable whenever a tick is consumed.

// File: rtl/ewc_pkg.sv
`timescale 1ns/1ps
package ewc_pkg;
   // Which oscillator body the bank builds.
   typedef enum logic {
      OSC_CLOCKED = 1'b0,   // registered stand-in for simulation and lint
      OSC_RING    = 1'b1    // true asynchronous adder-carry ring
   } osc_impl_e;
endpackage

// File: rtl/ewc_prescaler.sv
`timescale 1ns/1ps
module ewc_prescaler #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [DIV_W-1:0] reload,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (!en) begin
         cnt_q <= reload;
         tick  <= 1'b0;
      end else if (cnt_q == '0) begin
         cnt_q <= reload;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q - 1'b1;
         tick  <= 1'b0;
      end
   end

   // R2
   tick_single_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && en && reload != '0) |=> !tick);

   // R8
   tick_gated_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> !tick);
endmodule

// File: rtl/ewc_osc_bank.sv
`timescale 1ns/1ps
module ewc_osc_bank
   import ewc_pkg::*;
#(
   parameter int        NUM_OSC = 32,
   parameter int        OP_W    = 4,
   parameter osc_impl_e IMPL    = OSC_CLOCKED
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [OP_W-1:0]    opnd_a,
   input  logic [OP_W-1:0]    opnd_b,
   output logic [NUM_OSC-1:0] smp_q
);
   logic [NUM_OSC-1:0] osc_w;

   for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
      if (IMPL == OSC_RING) begin : g_ring
         logic            carry_w;
         logic [OP_W-1:0] unused_low;
         assign {carry_w, unused_low} = {1'b0, opnd_a} + {1'b0, opnd_b}
                                       + {{OP_W{1'b0}}, ~carry_w};
         assign osc_w[g] = carry_w;
      end else begin : g_clocked
         logic            st_q;
         logic            carry_w;
         logic [OP_W-1:0] unused_low;
         assign {carry_w, unused_low} = {1'b0, opnd_a} + {1'b0, opnd_b}
                                       + {{OP_W{1'b0}}, st_q};
         always_ff @(posedge clk) begin
            if (rst) st_q <= 1'((g % 3) == 0);
            else     st_q <= ~carry_w;
         end
         assign osc_w[g] = carry_w;
      end
   end

   // First capture of the asynchronous oscillator outputs.
   always_ff @(posedge clk) begin
      if (rst) smp_q <= '0;
      else     smp_q <= osc_w;
   end
endmodule

// File: rtl/ewc_packer.sv
`timescale 1ns/1ps
module ewc_packer #(
   parameter int NUM_OSC = 32,
   parameter int WORD_W  = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic               tick,
   input  logic [NUM_OSC-1:0] src,
   input  logic               ack,
   output logic [WORD_W-1:0]  data_q,
   output logic               valid_q
);
   localparam int              CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] shift_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              raw_bit;
   logic [WORD_W-1:0] next_word;
   logic              done;

   assign raw_bit   = ^src;
   assign next_word = {shift_q[WORD_W-2:0], raw_bit};
   assign done      = tick && en && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         shift_q <= '0;
         cnt_q   <= '0;
         data_q  <= '0;
         valid_q <= 1'b0;
      end else if (!en) begin
         cnt_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         if (tick) begin
            shift_q <= next_word;
            cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
         if (done && (!valid_q || ack)) begin
            data_q  <= next_word;
            valid_q <= 1'b1;
         end else if (ack) begin
            valid_q <= 1'b0;
         end
      end
   end

   // R5
   hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_q && !ack && en) |=> (valid_q && $stable(data_q)));

   // R6
   ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_q && ack && !done) |=> !valid_q);

   // R8
   disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> !valid_q);

   // R4
   valid_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(valid_q) |-> $past(tick));
endmodule

// File: rtl/entropy_word_collector.sv
`timescale 1ns/1ps
module entropy_word_collector
   import ewc_pkg::*;
#(
   parameter int        NUM_OSC = 32,
   parameter int        WORD_W  = 32,
   parameter int        DIV_W   = 16,
   parameter int        OP_W    = 4,
   parameter osc_impl_e IMPL    = OSC_CLOCKED
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               enable,
   input  logic [DIV_W-1:0]   period_cfg,
   input  logic [OP_W-1:0]    opnd_a,
   input  logic [OP_W-1:0]    opnd_b,
   input  logic               force_sel,
   input  logic [NUM_OSC-1:0] force_bits,
   input  logic               word_ack,
   output logic [WORD_W-1:0]  word_data,
   output logic               word_valid
);
   if (NUM_OSC < 1) begin : g_bad_osc
      $error("NUM_OSC must be at least 1");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("WORD_W must be at least 2");
   end
   if (DIV_W < 1 || OP_W < 1) begin : g_bad_width
      $error("DIV_W and OP_W must be at least 1");
   end

   logic               tick;
   logic [NUM_OSC-1:0] osc_smp;
   logic [NUM_OSC-1:0] src;

   ewc_prescaler #(.DIV_W(DIV_W)) u_presc (
      .clk(clk), .rst(rst), .en(enable), .reload(period_cfg), .tick(tick)
   );

   ewc_osc_bank #(.NUM_OSC(NUM_OSC), .OP_W(OP_W), .IMPL(IMPL)) u_bank (
      .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b), .smp_q(osc_smp)
   );

   assign src = force_sel ? force_bits : osc_smp;

   ewc_packer #(.NUM_OSC(NUM_OSC), .WORD_W(WORD_W)) u_pack (
      .clk(clk), .rst(rst), .en(enable), .tick(tick), .src(src),
      .ack(word_ack), .data_q(word_data), .valid_q(word_valid)
   );
endmodule

// File: tb/entropy_word_collector_tb.sv
`timescale 1ns/1ps
module entropy_word_collector_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        enable = 1'b0;
   logic [15:0] period_cfg = '0;
   logic [3:0]  opnd_a = '0;
   logic [3:0]  opnd_b = 4'hF;
   logic        force_sel = 1'b1;
   logic [31:0] force_bits = '0;
   logic        word_ack = 1'b0;
   logic [31:0] word_data;
   logic        word_valid;

   int total = 0;
   int fails = 0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   entropy_word_collector u_dut (
      .clk(clk), .rst(rst), .enable(enable), .period_cfg(period_cfg),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .force_sel(force_sel),
      .force_bits(force_bits), .word_ack(word_ack),
      .word_data(word_data), .word_valid(word_valid)
   );

   localparam logic [31:0] VEC_WORD [4] = '{32'hA5C3_0F96, 32'hFFFF_0000,
                                            32'h1234_5678, 32'h8000_0001};
   localparam logic [15:0] VEC_DIV  [4] = '{16'd3, 16'd0, 16'd5, 16'd1};
   localparam logic [31:0] VEC_BASE [4] = '{32'h0000_0001, 32'hDEAD_BEEF,
                                            32'h0000_0000, 32'hFFFF_FFFF};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Disable for one edge, load the period, re-enable, and align to the first window.
   task automatic begin_word(input logic [15:0] div);
      @(negedge clk);
      enable = 1'b0;
      period_cfg = div;
      @(negedge clk);
      enable = 1'b1;
      repeat (int'(div)) @(posedge clk);
   endtask

   // Present one raw bit whose parity is b, held over the sampling edge.
   task automatic push_bit(input logic b, input logic [15:0] div, input logic [31:0] base);
      @(negedge clk);
      force_bits = ((^base) == b) ? base : (base ^ 32'h1);
      repeat (int'(div) + 1) @(posedge clk);
   endtask

   task automatic push_word(input logic [31:0] w, input logic [15:0] div, input logic [31:0] base);
      for (int n = 0; n < 32; n++) push_bit(w[31-n], div, base);
   endtask

   task automatic ack_pulse();
      @(negedge clk);
      word_ack = 1'b1;
      @(negedge clk);
      word_ack = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", {31'b0, word_valid}, 32'h0);
      chk("R1 data in reset", word_data, 32'h0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 valid after reset", {31'b0, word_valid}, 32'h0);
      chk("R1 data after reset", word_data, 32'h0);

      // Table walk: R2 period, R3 XOR, R4 packing order, R5 hold, R6 ack.
      for (int v = 0; v < 4; v++) begin
         begin_word(VEC_DIV[v]);
         push_word(VEC_WORD[v], VEC_DIV[v], VEC_BASE[v]);
         @(negedge clk);
         chk("R4 valid after 32 samples", {31'b0, word_valid}, 32'h1);
         chk("R2/R3/R4 packed word", word_data, VEC_WORD[v]);
         repeat (2) @(negedge clk);
         chk("R5 valid held", {31'b0, word_valid}, 32'h1);
         chk("R5 data held", word_data, VEC_WORD[v]);
         ack_pulse();
         chk("R6 valid after ack", {31'b0, word_valid}, 32'h0);
      end

      // R7: second word completes while first is held.
      begin_word(16'd1);
      push_word(32'hCAFE_1234, 16'd1, 32'h0F0F_0F0F);
      push_word(32'h5555_AAAA, 16'd1, 32'h0F0F_0F0F);
      @(negedge clk);
      chk("R7 first word retained", word_data, 32'hCAFE_1234);
      chk("R7 valid still high", {31'b0, word_valid}, 32'h1);
      ack_pulse();
      chk("R7 overrun word dropped", {31'b0, word_valid}, 32'h0);

      // R8: disabling clears valid.
      begin_word(16'd2);
      push_word(32'h0BAD_F00D, 16'd2, 32'h0);
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk("R8 valid cleared by disable", {31'b0, word_valid}, 32'h0);
      // R8: partial word discarded on re-enable.
      begin_word(16'd2);
      for (int n = 0; n < 10; n++) push_bit(n[0], 16'd2, 32'h0);
      begin_word(16'd2);
      push_word(32'h7E57_C0DE, 16'd2, 32'h0000_00FF);
      @(negedge clk);
      chk("R8 fresh word after restart", word_data, 32'h7E57_C0DE);
      chk("R8 valid after restart", {31'b0, word_valid}, 32'h1);

      // R9: live oscillator path.
      force_sel = 1'b0;
      begin_word(16'd0);
      repeat (20) @(negedge clk);
      chk("R9 no word before 32 samples", {31'b0, word_valid}, 32'h0);
      repeat (20) @(negedge clk);
      chk("R9 word from oscillators", {31'b0, word_valid}, 32'h1);

      done_flag = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule